// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block produces the scan timing for a 640×480-class display raster in which only a 512×384 window carries text. A horizontal counter steps through every pixel slot of a line. A vertical counter steps through every line of a frame. The generator decodes these two counts into sync pulses and into two flags that mark the text window. The flags are kept separate so that a downstream colour stage can AND them together itself. All timing advances on a pixel-clock enable, so the block can run from a faster system clock.

Each character cell is three lines tall in the window. A three-line sub-counter advances a glyph row index once every third line, so no divider is needed to find the row. The sync start positions are parameters, so the picture can be moved on the screen. Each pulse width is a separate parameter, so moving the picture leaves the widths unchanged.

Every output comes from a register loaded on the same enabled tick. As a result, the position, the flags and the syncs always describe the same pixel slot.

Top module: `raster_timing_gen`

## Requirements
- R1: On each enabled tick the pixel position `px_x` advances by one, from 0 up to H_TOTAL-1 (default 799), and then returns to 0.
- R2: The line position `line_y` advances by one only on the tick where `px_x` wraps. It counts 0 up to V_TOTAL-1 (default 524) and then returns to 0.
- R3: `h_act` is 1 exactly when `px_x` is below H_ACT (default 512).
- R4: `v_act` is 1 exactly when `line_y` is below V_ACT (default 384).
- R5: `hsync` is 1 exactly when `px_x` is at least HS_START and below HS_START+HS_WIDTH. With the defaults this is 592 up to 687.
- R6: `vsync` is 1 exactly when `line_y` is at least VS_START and below VS_START+VS_WIDTH. With the defaults this is lines 443, 444 and 445.
- R7: `glyph_row` equals (`line_y` / LINES_PER_ROW) modulo (V_ACT / LINES_PER_ROW). With the defaults this means it advances once every three lines and returns to 0 after reaching 127. It is 0 on line 0 of every frame.
- R8: All outputs are registered. After k enabled ticks since reset (k ≥ 1), they describe scan slot k-1. A cycle without `pix_en` leaves every output unchanged.
- R9: While `rst_n` is low at a clock edge, every output is 0 on the next cycle, whatever `pix_en` is. The first enabled tick after reset reports slot (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel tick enable; one scan slot per enabled cycle |
| px_x | output | 10 | Pixel position within the line |
| line_y | output | 10 | Line position within the frame |
| hsync | output | 1 | Horizontal sync pulse, active high |
| vsync | output | 1 | Vertical sync pulse, active high |
| h_act | output | 1 | Pixel lies in the text window columns |
| v_act | output | 1 | Line lies in the text window rows |
| glyph_row | output | 7 | Character row index, one step per three lines |

## Verification
The checker does not trust any output relation until the first enabled tick after reset. It then assumes that `pix_en` is a plain level, sampled at the clock edge, and that reset is held for at least one edge. The bench drives `pix_en` and `rst_n` only on falling edges. It holds `pix_en` high during reset to show that reset has priority. It runs both continuous and gapped enable patterns. A default-sized instance covers the horizontal boundaries and the first row steps. A reduced-size instance is needed because a full default frame does not fit the cycle budget. It completes several frames, which exercises the vertical wrap, the vertical sync, and the clearing of the row index at frame start.

// File: rtl/raster_pkg.sv
// Shared helpers for the raster timing generator.
// Assumes: counts are unsigned; a range of 1 or 2 still needs one bit.
package raster_pkg;

    // Flag bundle registered alongside the scan position.
    typedef struct packed {
        logic hs;
        logic vs;
        logic ha;
        logic va;
    } scan_flags_t;

    // Bits needed to hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wrap_counter.sv
// Modulo counter: steps 0..LAST then back to 0; a clear takes priority.
// Assumes: LAST fits in W bits; step and clr are single-cycle qualifiers.
module wrap_counter #(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] LAST_V = W'(LAST);

    // Advance, wrap or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (step) begin
            count <= (count == LAST_V) ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/span_decode.sv
// Flags a count lying in the half-open band [LO, HI).
// Assumes: HI > LO and HI <= 2**W; a zero lower bound drops that compare.
module span_decode #(
    parameter int W  = 10,
    parameter int LO = 0,
    parameter int HI = 1
) (
    input  logic [W-1:0] cnt,
    output logic         hit
);

    localparam logic [W:0] HI_V = (W+1)'(HI);

    generate
        if (LO == 0) begin : g_below
            // Band starts at zero: only the upper bound matters.
            assign hit = ({1'b0, cnt} < HI_V);
        end else begin : g_band
            localparam logic [W:0] LO_V = (W+1)'(LO);
            // Band has both bounds.
            assign hit = ({1'b0, cnt} >= LO_V) && ({1'b0, cnt} < HI_V);
        end
    endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
// Raster timing generator: pixel/line counters, sync bands, window flags
// and a glyph row index stepped every LINES_PER_ROW lines.
// Assumes: pix_en marks one scan slot; V_ACT is a multiple of LINES_PER_ROW;
// all sync bands lie inside their totals. Outputs lag the counters by one
// enabled tick so every output describes the same slot.
module raster_timing_gen #(
    parameter int H_TOTAL       = 800,
    parameter int H_ACT         = 512,
    parameter int HS_START      = 592,
    parameter int HS_WIDTH      = 96,
    parameter int V_TOTAL       = 525,
    parameter int V_ACT         = 384,
    parameter int VS_START      = 443,
    parameter int VS_WIDTH      = 3,
    parameter int LINES_PER_ROW = 3
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 pix_en,
    output logic [raster_pkg::cnt_w(H_TOTAL)-1:0]                px_x,
    output logic [raster_pkg::cnt_w(V_TOTAL)-1:0]                line_y,
    output logic                                                 hsync,
    output logic                                                 vsync,
    output logic                                                 h_act,
    output logic                                                 v_act,
    output logic [raster_pkg::cnt_w(V_ACT / LINES_PER_ROW)-1:0]  glyph_row
);

    import raster_pkg::*;

    localparam int ROWS = V_ACT / LINES_PER_ROW;
    localparam int XW   = cnt_w(H_TOTAL);
    localparam int YW   = cnt_w(V_TOTAL);
    localparam int SW   = cnt_w(LINES_PER_ROW);
    localparam int RW   = cnt_w(ROWS);

    localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);
    localparam logic [SW-1:0] S_LAST = SW'(LINES_PER_ROW - 1);

    logic [XW-1:0] h_cnt;
    logic [YW-1:0] v_cnt;
    logic [SW-1:0] sub_cnt;
    logic [RW-1:0] row_cnt;
    logic          line_adv;
    logic          frame_adv;
    logic          row_adv;
    scan_flags_t   flags_d;
    scan_flags_t   flags_q;

    assign line_adv  = pix_en && (h_cnt == X_LAST);
    assign frame_adv = line_adv && (v_cnt == Y_LAST);
    assign row_adv   = line_adv && (sub_cnt == S_LAST);

    wrap_counter #(.W(XW), .LAST(H_TOTAL - 1)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .step(pix_en), .clr(1'b0), .count(h_cnt)
    );

    wrap_counter #(.W(YW), .LAST(V_TOTAL - 1)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .step(line_adv), .clr(1'b0), .count(v_cnt)
    );

    wrap_counter #(.W(SW), .LAST(LINES_PER_ROW - 1)) u_subcnt (
        .clk(clk), .rst_n(rst_n), .step(line_adv), .clr(frame_adv), .count(sub_cnt)
    );

    wrap_counter #(.W(RW), .LAST(ROWS - 1)) u_rowcnt (
        .clk(clk), .rst_n(rst_n), .step(row_adv), .clr(frame_adv), .count(row_cnt)
    );

    span_decode #(.W(XW), .LO(0), .HI(H_ACT)) u_hact (
        .cnt(h_cnt), .hit(flags_d.ha)
    );

    span_decode #(.W(YW), .LO(0), .HI(V_ACT)) u_vact (
        .cnt(v_cnt), .hit(flags_d.va)
    );

    span_decode #(.W(XW), .LO(HS_START), .HI(HS_START + HS_WIDTH)) u_hsync (
        .cnt(h_cnt), .hit(flags_d.hs)
    );

    span_decode #(.W(YW), .LO(VS_START), .HI(VS_START + VS_WIDTH)) u_vsync (
        .cnt(v_cnt), .hit(flags_d.vs)
    );

    // Capture position, row and flags of the current slot together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_x      <= '0;
            line_y    <= '0;
            glyph_row <= '0;
            flags_q   <= '0;
        end else if (pix_en) begin
            px_x      <= h_cnt;
            line_y    <= v_cnt;
            glyph_row <= row_cnt;
            flags_q   <= flags_d;
        end
    end

    assign hsync = flags_q.hs;
    assign vsync = flags_q.vs;
    assign h_act = flags_q.ha;
    assign v_act = flags_q.va;

endmodule

// File: rtl/raster_timing_chk.sv
// Property checker for raster_timing_gen, attached by bind.
// Assumes: pix_en is a level sampled at the edge; relations on the outputs
// are trusted only after the first enabled tick following reset.
module raster_timing_chk #(
    parameter int H_TOTAL       = 800,
    parameter int H_ACT         = 512,
    parameter int HS_START      = 592,
    parameter int HS_WIDTH      = 96,
    parameter int V_TOTAL       = 525,
    parameter int V_ACT         = 384,
    parameter int VS_START      = 443,
    parameter int VS_WIDTH      = 3,
    parameter int LINES_PER_ROW = 3
) (
    input logic                                                 clk,
    input logic                                                 rst_n,
    input logic                                                 pix_en,
    input logic [raster_pkg::cnt_w(H_TOTAL)-1:0]                px_x,
    input logic [raster_pkg::cnt_w(V_TOTAL)-1:0]                line_y,
    input logic                                                 hsync,
    input logic                                                 vsync,
    input logic                                                 h_act,
    input logic                                                 v_act,
    input logic [raster_pkg::cnt_w(V_ACT / LINES_PER_ROW)-1:0]  glyph_row
);

    localparam int XW = raster_pkg::cnt_w(H_TOTAL);
    localparam int YW = raster_pkg::cnt_w(V_TOTAL);

    localparam logic [XW:0] X_LAST = (XW+1)'(H_TOTAL - 1);
    localparam logic [YW:0] Y_LAST = (YW+1)'(V_TOTAL - 1);
    localparam logic [XW:0] HA_V   = (XW+1)'(H_ACT);
    localparam logic [YW:0] VA_V   = (YW+1)'(V_ACT);
    localparam logic [XW:0] HS_LO  = (XW+1)'(HS_START);
    localparam logic [XW:0] HS_HI  = (XW+1)'(HS_START + HS_WIDTH);
    localparam logic [YW:0] VS_LO  = (YW+1)'(VS_START);
    localparam logic [YW:0] VS_HI  = (YW+1)'(VS_START + VS_WIDTH);

    logic          started;
    logic [XW:0]   x_ext;
    logic [YW:0]   y_ext;

    assign x_ext = {1'b0, px_x};
    assign y_ext = {1'b0, line_y};

    // Mark that the outputs hold a real scan slot.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else if (pix_en) started <= 1'b1;
    end

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_en && x_ext != X_LAST) |=> (x_ext == $past(x_ext) + 1'b1)); // R1
    AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_en && x_ext == X_LAST) |=> (px_x == '0)); // R1
    AST_Y_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_en && x_ext == X_LAST && y_ext != Y_LAST) |=> (y_ext == $past(y_ext) + 1'b1)); // R2
    AST_Y_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_en && x_ext == X_LAST && y_ext == Y_LAST) |=> (line_y == '0)); // R2
    AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_en && x_ext != X_LAST) |=> $stable(line_y)); // R2
    AST_HACT_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (h_act == (x_ext < HA_V))); // R3
    AST_VACT_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (v_act == (y_ext < VA_V))); // R4
    AST_HSYNC_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (hsync == ((x_ext >= HS_LO) && (x_ext < HS_HI)))); // R5
    AST_VSYNC_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (vsync == ((y_ext >= VS_LO) && (y_ext < VS_HI)))); // R6
    AST_ROW_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        (started && line_y == '0) |-> (glyph_row == '0)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(px_x) && $stable(line_y) && $stable(hsync) && $stable(vsync)
                     && $stable(h_act) && $stable(v_act) && $stable(glyph_row))); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (px_x == '0 && line_y == '0 && !hsync && !vsync && !h_act && !v_act
                    && glyph_row == '0)); // R9

endmodule

bind raster_timing_gen raster_timing_chk #(
    .H_TOTAL(H_TOTAL), .H_ACT(H_ACT), .HS_START(HS_START), .HS_WIDTH(HS_WIDTH),
    .V_TOTAL(V_TOTAL), .V_ACT(V_ACT), .VS_START(VS_START), .VS_WIDTH(VS_WIDTH),
    .LINES_PER_ROW(LINES_PER_ROW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .px_x(px_x), .line_y(line_y),
    .hsync(hsync), .vsync(vsync), .h_act(h_act), .v_act(v_act), .glyph_row(glyph_row)
);

// File: tb/raster_timing_gen_tb.sv
// Directed bench: a default-sized instance and a reduced instance, both fed
// the same clock, reset and enable; expected outputs follow from the tick count.
module raster_timing_gen_tb;

    localparam int CLK_PERIOD = 10;

    // Reduced geometry so whole frames fit the run.
    localparam int S_HT = 40, S_HA = 16, S_HS = 24, S_HW = 6;
    localparam int S_VT = 30, S_VA = 12, S_VS = 20, S_VW = 3, S_LPR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;

    logic [9:0] d_x, d_y;
    logic [6:0] d_row;
    logic       d_hs, d_vs, d_ha, d_va;
    logic [5:0] s_x;
    logic [4:0] s_y;
    logic [1:0] s_row;
    logic       s_hs, s_vs, s_ha, s_va;

    int  checks = 0;
    int  failures = 0;
    int  ticks = 0;
    bit  done = 0;
    string scen = "reset";

    always #(CLK_PERIOD / 2) clk = ~clk;

    raster_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .px_x(d_x), .line_y(d_y), .hsync(d_hs), .vsync(d_vs),
        .h_act(d_ha), .v_act(d_va), .glyph_row(d_row)
    );

    raster_timing_gen #(
        .H_TOTAL(S_HT), .H_ACT(S_HA), .HS_START(S_HS), .HS_WIDTH(S_HW),
        .V_TOTAL(S_VT), .V_ACT(S_VA), .VS_START(S_VS), .VS_WIDTH(S_VW),
        .LINES_PER_ROW(S_LPR)
    ) u_dut_small (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .px_x(s_x), .line_y(s_y), .hsync(s_hs), .vsync(s_vs),
        .h_act(s_ha), .v_act(s_va), .glyph_row(s_row)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s [%s] tick=%0d actual=%0d expected=%0d",
                     req, what, scen, ticks, act, exp);
        end
    endtask

    // Expected outputs after k enabled ticks for one geometry.
    task automatic verify_cfg(input string who, input int k,
                              input int ht, input int ha, input int hs, input int hw,
                              input int vt, input int va, input int vs, input int vw,
                              input int lpr,
                              input int ax, input int ay, input int ahs, input int avs,
                              input int aha, input int ava, input int arow);
        int p, x, y, rows;
        rows = va / lpr;
        if (k == 0) begin
            chk("R9", {who, " x"}, ax, 0);
            chk("R9", {who, " y"}, ay, 0);
            chk("R9", {who, " hsync"}, ahs, 0);
            chk("R9", {who, " vsync"}, avs, 0);
            chk("R9", {who, " h_act"}, aha, 0);
            chk("R9", {who, " v_act"}, ava, 0);
            chk("R9", {who, " row"}, arow, 0);
        end else begin
            p = k - 1;
            x = p % ht;
            y = (p / ht) % vt;
            chk("R1", {who, " x"}, ax, x);
            chk("R2", {who, " y"}, ay, y);
            chk("R3", {who, " h_act"}, aha, (x < ha) ? 1 : 0);
            chk("R4", {who, " v_act"}, ava, (y < va) ? 1 : 0);
            chk("R5", {who, " hsync"}, ahs, (x >= hs && x < hs + hw) ? 1 : 0);
            chk("R6", {who, " vsync"}, avs, (y >= vs && y < vs + vw) ? 1 : 0);
            chk("R7", {who, " row"}, arow, (y / lpr) % rows);
        end
    endtask

    task automatic verify_all();
        verify_cfg("dflt", ticks, 800, 512, 592, 96, 525, 384, 443, 3, 3,
                   d_x, d_y, d_hs, d_vs, d_ha, d_va, d_row);
        verify_cfg("small", ticks, S_HT, S_HA, S_HS, S_HW, S_VT, S_VA, S_VS, S_VW, S_LPR,
                   s_x, s_y, s_hs, s_vs, s_ha, s_va, s_row);
    endtask

    // One cycle: check the slot reported now, then drive the next enable.
    task automatic step(input bit en);
        @(negedge clk);
        verify_all();
        pix_en = en;
        if (en && rst_n) ticks++;
    endtask

    // R9: reset with enable held high, outputs cleared.
    task automatic t_reset();
        scen = "R9 reset";
        @(negedge clk);
        rst_n = 1'b0;
        pix_en = 1'b1;
        repeat (3) @(negedge clk);
        ticks = 0;
        verify_all();
        rst_n = 1'b1;
        pix_en = 1'b0;
        step(1'b0);
    endtask

    // R1-R7: continuous enable across line, row and frame boundaries.
    task automatic t_run(input int n);
        scen = "R1-wrap continuous";
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    // R8: gapped enable, outputs hold on idle cycles.
    task automatic t_gated(input int n);
        scen = "R8 gated";
        for (int i = 0; i < n; i++) step((i % 3) != 0);
    endtask

    initial begin
        t_reset();
        t_run(2600);
        t_gated(300);
        t_reset();
        t_run(1300);
        step(1'b0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule